// File: doc/BRIEF.md
# Configurable 8-bit Synchronous Serial Port

This block moves one 8-bit frame at a time between the system and an external device over three lines: a shift clock, a data output and a data input. The system first loads a mode byte, then writes a data byte into the shift buffer. That write starts a frame. Over eight shift-clock periods the buffer contents leave on the data output while data-input bits are shifted into the same register. When the frame ends, the register holds the received byte and a completion flag is set.

The mode byte sets four things: transmit-and-receive or receive-only operation, the bit order (most significant or least significant bit first), the shift-clock source, and a rate for the internal source. The clock can come from a divided system clock, from an external clock on the shift-clock input, or from a strobe supplied by a neighbouring timer. In every mode the output bit changes on a falling shift-clock edge and the input bit is sampled on a rising edge. When the port drives the clock, the clock rests high between frames.

Top module: `sio_port`

## Requirements
- R1: After reset, sck_out and so are high, done is low, buf_out is zero, sck_oe is high, and the mode is internal clock, transmit-and-receive, most-significant-bit first, rate 0.
- R2: Mode byte layout is rate in bits 7:4, clock source in bits 3:2 (0 internal, 1 external, 2 timer strobe, 3 internal), least-significant-bit-first in bit 1 and receive-only in bit 0. With an internal source, each half period of sck_out lasts rate+1 system clocks. A frame has exactly eight falling edges, and done is set 16*(rate+1) clocks after the buffer write. sck_out then stays high.
- R3: In most-significant-bit-first order, so presents buf_in bits 7 down to 0 after successive falling edges, and the first bit received on si ends up in buf_out bit 7.
- R4: In least-significant-bit-first order, so presents buf_in bits 0 up to 7, and the first bit received ends up in buf_out bit 0.
- R5: In receive-only mode, so stays high for the whole frame while si is still received into buf_out.
- R6: With the external source, sck_oe is low and sck_out is high. so and si follow the falling and rising edges of sck_in, which is passed through a two-flop synchronizer. done sets after the eighth rising edge.
- R7: With the timer-strobe source, each one-cycle tmr_strobe pulse during a frame produces one sck_out half period, and sck_out does not change between strobes. done sets on the sixteenth strobe.
- R8: done sets when the eighth bit completes, holds until the next accepted buffer write, and is low in the cycle after that write.
- R9: A buffer write while a frame is in progress is ignored. The output sequence, the received byte and the frame length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_mode | input | 1 | Mode register write strobe |
| mode_in | input | 8 | Mode byte |
| wr_buf | input | 1 | Buffer write strobe; starts a frame when idle |
| buf_in | input | 8 | Byte to transmit |
| tmr_strobe | input | 1 | One-cycle clock strobe from timer |
| sck_in | input | 1 | External shift clock |
| si | input | 1 | Serial data input |
| sck_out | output | 1 | Driven shift clock |
| sck_oe | output | 1 | High when the port drives the shift clock |
| so | output | 1 | Serial data output |
| done | output | 1 | Frame completion flag |
| buf_out | output | 8 | Shift register contents (received byte after a frame) |

## Verification
The assertions assume that the mode register is written only between frames. They also assume that an external clock rests high while idle and holds each level for longer than the synchronizer delay, and that tmr_strobe pulses are a single cycle wide. The bench writes the mode only before it loads the buffer. It holds each external clock level for six system clocks, and it separates timer strobes by idle cycles. The one stray write it issues during a frame targets only the buffer, so the ignore rule is exercised without breaking these assumptions.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int FRAME_W = 8;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int RATE_W  = 4;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_TMR = 2'd2,
    SRC_ALT = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    clk_src_e          src;
    logic              lsb_first;
    logic              rx_only;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  // Length of one shift-clock half period in system clocks.
  function automatic logic [RATE_W:0] half_period(input logic [RATE_W-1:0] rate);
    return {1'b0, rate} + {{RATE_W{1'b0}}, 1'b1};
  endfunction

  // Bit that leaves the register next.
  function automatic logic out_bit(input logic [FRAME_W-1:0] sr, input logic lsb_first);
    return lsb_first ? sr[0] : sr[FRAME_W-1];
  endfunction

  // Register after one received bit enters.
  function automatic logic [FRAME_W-1:0] shift_in(input logic [FRAME_W-1:0] sr,
                                                  input logic si, input logic lsb_first);
    return lsb_first ? {si, sr[FRAME_W-1:1]} : {sr[FRAME_W-2:0], si};
  endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              busy,
  input  clk_src_e          src,
  input  logic [RATE_W-1:0] rate,
  input  logic              tmr_strobe,
  input  logic              ext_rise,
  input  logic              ext_fall,
  output logic              sck_q,
  output logic              fall_ev,
  output logic              rise_ev
);
  logic [RATE_W:0] div_q;
  logic            tick;
  logic            own_clk;

  assign own_clk = (src != SRC_EXT);

  always_comb begin
    tick = 1'b0;
    if (busy) begin
      case (src)
        SRC_TMR: tick = tmr_strobe;
        SRC_EXT: tick = 1'b0;
        default: tick = ((div_q + {{RATE_W{1'b0}}, 1'b1}) == half_period(rate));
      endcase
    end
  end

  assign fall_ev = own_clk ? (tick & sck_q)  : (busy & ext_fall);
  assign rise_ev = own_clk ? (tick & ~sck_q) : (busy & ext_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (start) begin
      div_q <= '0;
      sck_q <= 1'b1;
    end else if (busy && own_clk) begin
      if (tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
      end else if (src != SRC_TMR) begin
        div_q <= div_q + {{RATE_W{1'b0}}, 1'b1};
      end
    end
  end
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
  import sio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_buf,
  input  logic [FRAME_W-1:0] buf_in,
  input  logic               fall_ev,
  input  logic               rise_ev,
  input  logic               si,
  input  logic               lsb_first,
  output logic               start,
  output logic               busy,
  output logic               done,
  output logic               so_q,
  output logic [FRAME_W-1:0] sr,
  output logic [CNT_W-1:0]   cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  assign start = wr_buf & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      so_q <= 1'b1;
      sr   <= '0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      so_q <= 1'b1;
      sr   <= buf_in;
      cnt  <= '0;
    end else if (busy) begin
      if (fall_ev) so_q <= out_bit(sr, lsb_first);
      if (rise_ev) begin
        sr  <= shift_in(sr, si, lsb_first);
        cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mode,
  input  logic [MODE_W-1:0]  mode_in,
  input  logic               wr_buf,
  input  logic [FRAME_W-1:0] buf_in,
  input  logic               tmr_strobe,
  input  logic               sck_in,
  input  logic               si,
  output logic               sck_out,
  output logic               sck_oe,
  output logic               so,
  output logic               done,
  output logic [FRAME_W-1:0] buf_out
);
  mode_t            mode_q;
  logic             start, busy, so_q, sck_q;
  logic             fall_ev, rise_ev, ext_rise, ext_fall;
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= mode_t'(mode_in);
  end

  sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sck_in), .rise(ext_rise), .fall(ext_fall)
  );

  sio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .src(mode_q.src), .rate(mode_q.rate), .tmr_strobe(tmr_strobe),
    .ext_rise(ext_rise), .ext_fall(ext_fall),
    .sck_q(sck_q), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .buf_in(buf_in),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .si(si), .lsb_first(mode_q.lsb_first),
    .start(start), .busy(busy), .done(done), .so_q(so_q), .sr(buf_out), .cnt(bit_cnt)
  );

  assign sck_oe  = (mode_q.src != SRC_EXT);
  assign sck_out = sck_oe ? sck_q : 1'b1;
  assign so      = (busy && !mode_q.rx_only) ? so_q : 1'b1;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
  import sio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             fall_ev,
  input logic             rise_ev,
  input logic [CNT_W-1:0] cnt,
  input logic             wr_buf,
  input logic             so,
  input logic             sck_out,
  input logic             sck_oe,
  input logic             done,
  input logic             rx_only
);
  // R2
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && sck_oe) |-> sck_out);

  // R2
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev));

  // R5
  rx_only_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rx_only) |-> so);

  // R8
  done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rise_ev && cnt == CNT_W'(FRAME_W - 1)) |=> (done && !busy));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_buf) |=> done);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_buf && !rise_ev) |=> (busy && cnt == $past(cnt)));
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .fall_ev(fall_ev), .rise_ev(rise_ev),
  .cnt(bit_cnt), .wr_buf(wr_buf), .so(so), .sck_out(sck_out), .sck_oe(sck_oe),
  .done(done), .rx_only(mode_q.rx_only)
);

// File: tb/sio_port_test.sv
module sio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_mode = 1'b0;
  logic [7:0] mode_in = '0;
  logic       wr_buf = 1'b0;
  logic [7:0] buf_in = '0;
  logic       tmr_strobe = 1'b0;
  logic       sck_in = 1'b1;
  logic       si = 1'b0;
  logic       sck_out, sck_oe, so, done;
  logic [7:0] buf_out;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sio_port uut (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .mode_in(mode_in),
    .wr_buf(wr_buf), .buf_in(buf_in), .tmr_strobe(tmr_strobe),
    .sck_in(sck_in), .si(si), .sck_out(sck_out), .sck_oe(sck_oe),
    .so(so), .done(done), .buf_out(buf_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk);
    mode_in = m;
    wr_mode = 1'b1;
    @(negedge clk);
    wr_mode = 1'b0;
  endtask

  task automatic load_buf(input logic [7:0] tx);
    @(negedge clk);
    buf_in = tx;
    wr_buf = 1'b1;
    @(negedge clk);
    wr_buf = 1'b0;
  endtask

  // R1
  task automatic test_reset();
    chk(sck_out == 1'b1, "R1", "sck_out", sck_out, 1);
    chk(so == 1'b1, "R1", "so", so, 1);
    chk(done == 1'b0, "R1", "done", done, 0);
    chk(buf_out == 8'h00, "R1", "buf_out", buf_out, 0);
    chk(sck_oe == 1'b1, "R1", "sck_oe", sck_oe, 1);
  endtask

  // Port drives the clock; bench acts as the far-end device.
  task automatic run_own(input logic [7:0] m, input logic [7:0] tx,
                         input logic [7:0] rx, input bit inject, input string req);
    int n = 0;
    int k = 0;
    int hp = int'(m[7:4]) + 1;
    bit lsb = m[1];
    bit rxo = m[0];
    bit prev;
    bit expb;
    set_mode(m);
    load_buf(tx);
    chk(done == 1'b0, "R8", "done cleared by write", done, 0);
    prev = sck_out;
    do begin
      @(negedge clk);
      wr_buf = 1'b0;
      n++;
      if (prev && !sck_out) begin
        expb = rxo ? 1'b1 : (lsb ? tx[k] : tx[7-k]);
        chk(so == expb, req, "so bit", so, expb);
        si = lsb ? rx[k] : rx[7-k];
        k++;
        if (inject && k == 3) begin
          buf_in = ~tx;
          wr_buf = 1'b1;
        end
      end
      prev = sck_out;
    end while (!done && n < 4000);
    chk(n == 16 * hp, "R2", "frame length", n, 16 * hp);
    chk(k == 8, "R2", "falling edges", k, 8);
    chk(buf_out == rx, req, "received byte", buf_out, rx);
    chk(done == 1'b1, "R8", "done set", done, 1);
    chk(so == 1'b1, req, "so idle", so, 1);
    repeat (2 * hp + 3) @(negedge clk);
    chk(sck_out == 1'b1, "R2", "sck stopped high", sck_out, 1);
    chk(done == 1'b1, "R8", "done held", done, 1);
  endtask

  // R6: bench drives the external clock.
  task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx);
    set_mode({4'd0, 2'b01, 1'b0, 1'b0});
    chk(sck_oe == 1'b0, "R6", "sck_oe", sck_oe, 0);
    load_buf(tx);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sck_in = 1'b0;
      si = rx[7-k];
      repeat (6) @(negedge clk);
      chk(so == tx[7-k], "R6", "so bit", so, tx[7-k]);
      chk(sck_out == 1'b1, "R6", "sck_out parked", sck_out, 1);
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      chk(done == (k == 7), "R6", "done timing", done, k == 7);
    end
    chk(buf_out == rx, "R6", "received byte", buf_out, rx);
  endtask

  // R7: timer strobes pace the clock.
  task automatic run_tmr(input logic [7:0] tx, input logic [7:0] rx);
    bit prev;
    int k = 0;
    set_mode({4'd0, 2'b10, 1'b1, 1'b0});
    load_buf(tx);
    prev = sck_out;
    for (int s = 0; s < 16; s++) begin
      repeat (3) @(negedge clk);
      chk(sck_out == prev, "R7", "no toggle without strobe", sck_out, prev);
      tmr_strobe = 1'b1;
      @(negedge clk);
      tmr_strobe = 1'b0;
      chk(sck_out != prev, "R7", "toggle on strobe", sck_out, !prev);
      if (prev && !sck_out) begin
        chk(so == tx[k], "R7", "so bit", so, tx[k]);
        si = rx[k];
        k++;
      end
      prev = sck_out;
      chk(done == (s == 15), "R7", "done on 16th strobe", done, s == 15);
    end
    chk(buf_out == rx, "R7", "received byte", buf_out, rx);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    run_own({4'd0, 2'b00, 1'b0, 1'b0}, 8'hA5, 8'h3C, 1'b0, "R3");
    run_own({4'd2, 2'b00, 1'b1, 1'b0}, 8'h96, 8'hC1, 1'b0, "R4");
    run_own({4'd1, 2'b00, 1'b0, 1'b1}, 8'h00, 8'h5A, 1'b0, "R5");
    run_own({4'd3, 2'b00, 1'b0, 1'b0}, 8'h81, 8'h7E, 1'b1, "R9");
    run_own({4'd0, 2'b11, 1'b1, 1'b0}, 8'h6D, 8'hB2, 1'b0, "R2");
    run_ext(8'hC3, 8'h1F);
    run_tmr(8'h4B, 8'hE8);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule